// File: doc/BRIEF.md
# Three-Port Registered Bus Exchanger

The block moves 16-bit words among three ports, A, B and C. Every port has an input storage element that works as a latch and as an edge-triggered register together. With its latch enable high the element is transparent. With the latch enable low it either keeps its contents or, when its active-low clock enable is low, loads the port input on a rising edge of that port's own clock. Each port's output is fed from the storage of one of the other two ports, picked by that port's select input. An active-low output enable decides whether the port drives at all.

The design runs on one system clock. The three port clocks are treated as ordinary control inputs, sampled on that clock. A port edge is a sample of 1 that follows a sample of 0. The storage view handed to the output path is combinational while a port is transparent, so live data crosses to the other ports in the same cycle. Output data and drive flags are plain signals with no handshake. The block has no flow control and cannot apply back-pressure: a consumer must take each value while its drive flag is high.

Top module: `bux_exchanger`

## Requirements
- R1: While a port's latch enable is high, its storage follows the port input. Any port selecting it shows that input in the same cycle, and the storage holds the last value seen at the system clock edge.
- R2: While the latch enable is low and the sampled port clock stays at one level, either low or high, the storage keeps its contents whatever the port input does.
- R3: With the latch enable low and the clock enable low, a rising port clock edge loads the port input present at the system clock edge where the edge is first seen.
- R4: With the latch enable low and the clock enable high, a rising port clock edge leaves the storage unchanged.
- R5: Select value 0 routes from the next port in the cycle A to B to C to A, so A takes B, B takes C and C takes A. Select value 1 routes from the remaining port, so A takes C, B takes A and C takes B.
- R6: One port's storage may feed both other ports at once, and both show the same word.
- R7: A port's drive flag is high exactly when its output enable is low and reset is released. While the drive flag is low, that port's data output reads all zeros.
- R8: Reset is active-low. It clears all three storage elements to zero and holds every drive flag low until it is released.
- R9: A port clock that is already high when reset is released produces no edge. It must first be sampled low and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_din | input | 16 | Port A input data |
| a_le | input | 1 | Port A latch enable (high = transparent) |
| a_pclk | input | 1 | Port A storage clock |
| a_cen_n | input | 1 | Port A active-low clock enable |
| a_oe_n | input | 1 | Port A active-low output enable |
| a_sel | input | 1 | Port A source select |
| a_dout | output | 16 | Port A output data |
| a_drv | output | 1 | Port A drive flag |
| b_din | input | 16 | Port B input data |
| b_le | input | 1 | Port B latch enable |
| b_pclk | input | 1 | Port B storage clock |
| b_cen_n | input | 1 | Port B active-low clock enable |
| b_oe_n | input | 1 | Port B active-low output enable |
| b_sel | input | 1 | Port B source select |
| b_dout | output | 16 | Port B output data |
| b_drv | output | 1 | Port B drive flag |
| c_din | input | 16 | Port C input data |
| c_le | input | 1 | Port C latch enable |
| c_pclk | input | 1 | Port C storage clock |
| c_cen_n | input | 1 | Port C active-low clock enable |
| c_oe_n | input | 1 | Port C active-low output enable |
| c_sel | input | 1 | Port C source select |
| c_dout | output | 16 | Port C output data |
| c_drv | output | 1 | Port C drive flag |

## Verification
The bench holds the port clock steady at each level while the input changes. A design that treats a level as an edge would pick up the new word. It also raises the port clock with the clock enable high, so a design that ignores the enable would load data. A port clock held high across reset release is the edge-detector corner: a detector that resets to the wrong level captures a spurious word. All six select routes and one-to-two fan-out are walked with distinct words, so a swapped mux leg shows the wrong word. A transparent port is observed in the same cycle, which catches a design that registers the live path and so answers one cycle late.

// File: rtl/bux_pkg.sv
package bux_pkg;
  localparam int unsigned NPORT  = 3;
  localparam int unsigned DATA_W = 16;

  typedef enum logic {
    SRC_NEXT = 1'b0,
    SRC_OTHER = 1'b1
  } src_sel_e;

  function automatic int unsigned next_port(input int unsigned idx);
    return (idx + 1) % NPORT;
  endfunction

  function automatic int unsigned other_port(input int unsigned idx);
    return (idx + 2) % NPORT;
  endfunction
endpackage

// File: rtl/bux_store.sv
module bux_store #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic         le,
  input  logic         pclk,
  input  logic         cen_n,
  output logic [W-1:0] q,
  output logic [W-1:0] view
);
  logic pclk_q;
  logic rise;

  // Resetting to 1 keeps a clock already high at release from reading as an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pclk_q <= 1'b1;
    else        pclk_q <= pclk;
  end

  assign rise = pclk & ~pclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (le)               q <= d;
    else if (rise && !cen_n)   q <= d;
  end

  assign view = le ? d : q;
endmodule

// File: rtl/bux_route.sv
module bux_route #(
  parameter int unsigned W   = 16,
  parameter int unsigned IDX = 0
) (
  input  logic         rst_n,
  input  logic [W-1:0] view_v [3],
  input  logic         sel,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         drv
);
  import bux_pkg::*;
  localparam int unsigned NXT = next_port(IDX);
  localparam int unsigned OTH = other_port(IDX);

  logic [W-1:0] pick;

  always_comb begin
    if (src_sel_e'(sel) == SRC_NEXT) pick = view_v[NXT];
    else                             pick = view_v[OTH];
  end

  assign drv  = rst_n & ~oe_n;
  assign dout = drv ? pick : '0;
endmodule

// File: rtl/bux_exchanger.sv
module bux_exchanger #(
  parameter int unsigned W = bux_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_din,
  input  logic         a_le,
  input  logic         a_pclk,
  input  logic         a_cen_n,
  input  logic         a_oe_n,
  input  logic         a_sel,
  output logic [W-1:0] a_dout,
  output logic         a_drv,
  input  logic [W-1:0] b_din,
  input  logic         b_le,
  input  logic         b_pclk,
  input  logic         b_cen_n,
  input  logic         b_oe_n,
  input  logic         b_sel,
  output logic [W-1:0] b_dout,
  output logic         b_drv,
  input  logic [W-1:0] c_din,
  input  logic         c_le,
  input  logic         c_pclk,
  input  logic         c_cen_n,
  input  logic         c_oe_n,
  input  logic         c_sel,
  output logic [W-1:0] c_dout,
  output logic         c_drv
);
  localparam int unsigned NP = bux_pkg::NPORT;

  logic [W-1:0] din_v  [NP];
  logic [W-1:0] held_v [NP];
  logic [W-1:0] view_v [NP];
  logic [W-1:0] dout_v [NP];
  logic [NP-1:0] le_v, pclk_v, cen_n_v, oe_n_v, sel_v, drv_v;

  assign din_v[0] = a_din;
  assign din_v[1] = b_din;
  assign din_v[2] = c_din;
  assign le_v     = {c_le, b_le, a_le};
  assign pclk_v   = {c_pclk, b_pclk, a_pclk};
  assign cen_n_v  = {c_cen_n, b_cen_n, a_cen_n};
  assign oe_n_v   = {c_oe_n, b_oe_n, a_oe_n};
  assign sel_v    = {c_sel, b_sel, a_sel};

  for (genvar i = 0; i < NP; i++) begin : g_port
    bux_store #(.W(W)) store_i (
      .clk(clk), .rst_n(rst_n), .d(din_v[i]), .le(le_v[i]),
      .pclk(pclk_v[i]), .cen_n(cen_n_v[i]), .q(held_v[i]), .view(view_v[i])
    );
    bux_route #(.W(W), .IDX(i)) route_i (
      .rst_n(rst_n), .view_v(view_v), .sel(sel_v[i]), .oe_n(oe_n_v[i]),
      .dout(dout_v[i]), .drv(drv_v[i])
    );
  end

  assign a_dout = dout_v[0];
  assign b_dout = dout_v[1];
  assign c_dout = dout_v[2];
  assign a_drv  = drv_v[0];
  assign b_drv  = drv_v[1];
  assign c_drv  = drv_v[2];
endmodule

// File: rtl/bux_checker.sv
module bux_checker #(
  parameter int unsigned W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  din_v  [3],
  input logic [W-1:0]  held_v [3],
  input logic [W-1:0]  dout_v [3],
  input logic [2:0]    le_v,
  input logic [2:0]    pclk_v,
  input logic [2:0]    cen_n_v,
  input logic [2:0]    oe_n_v,
  input logic [2:0]    sel_v,
  input logic [2:0]    drv_v
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    if (!rst_n) AST_QUIET_IN_RESET: assert (drv_v == 3'b000); // R8
  end

  for (genvar i = 0; i < 3; i++) begin : g_chk
    AST_TRANSPARENT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      le_v[i] |=> held_v[i] == $past(din_v[i])); // R1
    AST_STEADY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !le_v[i] && pclk_v[i] == $past(pclk_v[i])) |=> $stable(held_v[i])); // R2
    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !le_v[i] && !cen_n_v[i] && pclk_v[i] && !$past(pclk_v[i]))
        |=> held_v[i] == $past(din_v[i])); // R3
    AST_GATED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_v[i] && cen_n_v[i]) |=> $stable(held_v[i])); // R4
    AST_SEL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_v[i] && !sel_v[i] && !le_v[(i+1)%3]) |-> dout_v[i] == held_v[(i+1)%3]); // R5
    AST_SEL_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_v[i] && sel_v[i] && !le_v[(i+2)%3]) |-> dout_v[i] == held_v[(i+2)%3]); // R5
    AST_DRIVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      drv_v[i] == !oe_n_v[i]); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_v[i] |-> dout_v[i] == '0); // R7
  end
endmodule

bind bux_exchanger bux_checker #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .din_v(din_v), .held_v(held_v), .dout_v(dout_v),
  .le_v(le_v), .pclk_v(pclk_v), .cen_n_v(cen_n_v), .oe_n_v(oe_n_v),
  .sel_v(sel_v), .drv_v(drv_v)
);

// File: tb/bux_exchanger_tb_top.sv
module bux_exchanger_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] din [3];
  logic [2:0] le, pclk, cen_n, oe_n, sel;
  logic [15:0] dout [3];
  logic [2:0] drv;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bux_exchanger dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_din(din[0]), .a_le(le[0]), .a_pclk(pclk[0]), .a_cen_n(cen_n[0]),
    .a_oe_n(oe_n[0]), .a_sel(sel[0]), .a_dout(dout[0]), .a_drv(drv[0]),
    .b_din(din[1]), .b_le(le[1]), .b_pclk(pclk[1]), .b_cen_n(cen_n[1]),
    .b_oe_n(oe_n[1]), .b_sel(sel[1]), .b_dout(dout[1]), .b_drv(drv[1]),
    .c_din(din[2]), .c_le(le[2]), .c_pclk(pclk[2]), .c_cen_n(cen_n[2]),
    .c_oe_n(oe_n[2]), .c_sel(sel[2]), .c_dout(dout[2]), .c_drv(drv[2])
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Port j shows port src's storage: sel 0 takes the next port, sel 1 the remaining one.
  task automatic route(input int src, input int j);
    sel[j] = (src == (j + 1) % 3) ? 1'b0 : 1'b1;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      din[i] = 16'h1111 * (i + 1); le[i] = 1'b1; pclk[i] = 1'b0;
      cen_n[i] = 1'b1; oe_n[i] = 1'b0; sel[i] = 1'b0;
    end
    rst_n = 1'b0;
    step(3); #1;
    chk("R8 drive low in reset", {13'd0, drv}, 16'h0);
    chk("R8 data zero in reset", dout[0] | dout[1] | dout[2], 16'h0);
    le = 3'b000;
    step(1);
    rst_n = 1'b1;
    step(1); #1;
    chk("R8 cleared A", dout[2], 16'h0);
    chk("R8 cleared B", dout[0], 16'h0);
    chk("R8 cleared C", dout[1], 16'h0);
    chk("R7 drive after release", {13'd0, drv}, 16'h7);
  endtask

  task automatic t_transparent_hold();
    route(0, 1);
    le[0] = 1'b1; din[0] = 16'hA5A5; #1;
    chk("R1 live pass-through", dout[1], 16'hA5A5);
    din[0] = 16'h5A5A; #1;
    chk("R1 follows input", dout[1], 16'h5A5A);
    step(1);
    le[0] = 1'b0; din[0] = 16'h0F0F; #1;
    chk("R1 holds last sampled", dout[1], 16'h5A5A);
    cen_n[0] = 1'b0; pclk[0] = 1'b0;
    step(3); #1;
    chk("R2 hold clock low", dout[1], 16'h5A5A);
    pclk[0] = 1'b1; cen_n[0] = 1'b1;
    step(1);
    cen_n[0] = 1'b0; din[0] = 16'h3C3C;
    step(3); #1;
    chk("R2 hold clock high", dout[1], 16'h5A5A);
    pclk[0] = 1'b0; step(1);
  endtask

  task automatic t_capture();
    route(0, 1);
    le[0] = 1'b0; cen_n[0] = 1'b0; din[0] = 16'hBEEF; pclk[0] = 1'b1;
    step(1);
    din[0] = 16'h0000; #1;
    chk("R3 capture on rise", dout[1], 16'hBEEF);
    pclk[0] = 1'b0; step(1);
    cen_n[0] = 1'b1; din[0] = 16'hDEAD; pclk[0] = 1'b1;
    step(2); #1;
    chk("R4 gated edge ignored", dout[1], 16'hBEEF);
    pclk[0] = 1'b0; step(1);
  endtask

  task automatic t_select();
    logic [15:0] w [3];
    w[0] = 16'h1A1A; w[1] = 16'h2B2B; w[2] = 16'h3C3C;
    for (int i = 0; i < 3; i++) begin din[i] = w[i]; le[i] = 1'b1; end
    step(1);
    le = 3'b000;
    for (int i = 0; i < 3; i++) din[i] = 16'hFFFF;
    for (int s = 0; s < 2; s++) begin
      sel = {3{s[0]}}; #1;
      for (int j = 0; j < 3; j++)
        chk($sformatf("R5 port %0d sel %0d", j, s), dout[j], w[(j + 1 + s) % 3]);
    end
    route(2, 0); route(2, 1); #1;
    chk("R6 fan-out to A", dout[0], w[2]);
    chk("R6 fan-out to B", dout[1], w[2]);
  endtask

  task automatic t_oe();
    for (int j = 0; j < 3; j++) begin
      oe_n = 3'b000; oe_n[j] = 1'b1; #1;
      chk($sformatf("R7 port %0d flag", j), {15'd0, drv[j]}, 16'h0);
      chk($sformatf("R7 port %0d data", j), dout[j], 16'h0);
      chk($sformatf("R7 port %0d others", j), {13'd0, drv}, 16'h7 & ~(16'h1 << j));
    end
    oe_n = 3'b000;
  endtask

  task automatic t_sync_edge();
    le = 3'b000; cen_n = 3'b000; pclk = 3'b111; oe_n = 3'b000;
    din[0] = 16'h7777; route(0, 1);
    rst_n = 1'b0; step(2);
    rst_n = 1'b1; step(3); #1;
    chk("R9 no edge at release", dout[1], 16'h0);
    pclk[0] = 1'b0; step(1);
    pclk[0] = 1'b1; step(1); #1;
    chk("R9 later edge captures", dout[1], 16'h7777);
  endtask

  initial begin
    t_reset();
    t_transparent_hold();
    t_capture();
    t_select();
    t_oe();
    t_sync_edge();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule